// File: doc/BRIEF.md
# Processor-to-accelerator stream link channel

This block is one rate-decoupling channel between a processor pipeline and a hardware accelerator. It carries 32-bit words plus a one-bit control tag in a single direction, fixed at build time by a parameter. A small shift-register FIFO sits in the middle. The processor side sees a single request port. A request completes at once when the FIFO allows it. Otherwise the result depends on the request's mode. A blocking request holds the pipeline through a combinational stall. A non-blocking request completes at once and reports failure.

The accelerator side is a valid/ready stream. When the channel runs toward the accelerator, the processor writes and the accelerator drains an output stream. When it runs toward the processor, the accelerator fills an input stream and the processor reads. A registered carry-style status bit records whether the most recently completed processor request failed. Everything runs on one clock with a synchronous active-high reset.

Top module: `strm_link_chan`

## Requirements
- R1: With DIR = DIR_TO_ACC (1), every accepted processor write places {tag, data} into the FIFO. The accelerator receives these words in write order on acc_out_data and acc_out_tag, and acc_out_valid is high whenever at least one word is held.
- R2: A word leaves toward the accelerator only in a cycle where acc_out_valid and acc_out_ready are both high. While valid is high and ready is low, the presented data and tag stay unchanged.
- R3: The FIFO holds at most DEPTH words. Once it holds DEPTH words, further pushes are refused unless a pop happens in the same cycle.
- R4: A blocking write to a full FIFO raises cpu_stall with cpu_ok low and pushes nothing. It completes (stall low, ok high) in the first cycle that space exists, including a cycle where the accelerator pops.
- R5: A non-blocking write to a full FIFO does not stall. It returns cpu_ok low and drops the word.
- R6: With DIR = DIR_FROM_ACC (0), acc_in_ready is high when the FIFO is not full or the processor pops in that cycle. Accepted words reach the processor in order on cpu_rdata and cpu_rtag.
- R7: A blocking read from an empty FIFO stalls. A word pushed in the same cycle does not bypass the FIFO, so the read completes in the following cycle.
- R8: A non-blocking read from an empty FIFO does not stall, returns cpu_ok low and removes nothing.
- R9: cpu_carry updates on every completed processor request (request high, stall low). The clock edge that ends the request writes 1 into it if the request failed and 0 if it succeeded.
- R10: A push and a pop in the same cycle on a full FIFO leave it full.
- R11: Synchronous reset empties the FIFO and clears cpu_carry. While reset is high, cpu_stall and cpu_ok are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request (write if DIR_TO_ACC, read if DIR_FROM_ACC) |
| cpu_blocking | input | 1 | 1 = blocking access, 0 = non-blocking |
| cpu_wdata | input | DATA_W | Write data from the processor |
| cpu_wtag | input | 1 | Control tag written with the data |
| cpu_rdata | output | DATA_W | Read data to the processor (undefined when the read fails) |
| cpu_rtag | output | 1 | Control tag read with the data |
| cpu_stall | output | 1 | Pipeline stall for a blocking access that cannot complete |
| cpu_ok | output | 1 | Access completes successfully in this cycle |
| cpu_carry | output | 1 | Failure status of the last completed access |
| acc_in_valid | input | 1 | Accelerator offers a word |
| acc_in_ready | output | 1 | Channel accepts the offered word |
| acc_in_data | input | DATA_W | Word from the accelerator |
| acc_in_tag | input | 1 | Tag from the accelerator |
| acc_out_valid | output | 1 | Word available for the accelerator |
| acc_out_ready | input | 1 | Accelerator takes the word |
| acc_out_data | output | DATA_W | Word to the accelerator |
| acc_out_tag | output | 1 | Tag to the accelerator |

## Verification
The bench goes after three kinds of corner case.

The first is fill counts from zero to two past capacity, in both directions. A design that miscounted would lose or duplicate the oldest word, or accept a word past DEPTH.

The second is a blocking write held against a full FIFO until the accelerator pops, and a push and pop together at full. A design that looked only at the full flag would wrongly keep stalling. A design whose count update mishandled the pair would drop to DEPTH-1 or overflow.

The third has three parts:
- A blocking read waiting on an empty FIFO while a word arrives. A design with a hidden bypass would complete early.
- Non-blocking failures followed by successes. A design that failed to update the carry bit would report stale status.
- Reset asserted under a pending stall with the FIFO full. A design with an asynchronous or incomplete clear would leave words or carry behind.

// File: rtl/slc_pkg.sv
package slc_pkg;

    // Direction of the one-way channel, fixed at build time
    typedef enum logic {
        DIR_FROM_ACC = 1'b0,
        DIR_TO_ACC   = 1'b1
    } slc_dir_e;

    // Registered state of the processor-side port
    typedef struct packed {
        logic carry;
    } slc_cpu_st_t;

endpackage

// File: rtl/slc_fifo.sv
module slc_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_word,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] slot;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [CW-1:0] wr_idx;

    always_comb begin
        st_d   = st_q;
        wr_idx = pop ? st_q.cnt - CW'(1) : st_q.cnt;
        if (pop) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                st_d.slot[i] = st_q.slot[i+1];
            end
            st_d.slot[DEPTH-1] = '0;
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (push && (CW'(i) == wr_idx)) begin
                st_d.slot[i] = push_word;
            end
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head  = st_q.slot[0];
    assign occ   = st_q.cnt;
    assign full  = (st_q.cnt == CW'(DEPTH));
    assign empty = (st_q.cnt == '0);

endmodule

// File: rtl/slc_cpu_port.sv
module slc_cpu_port
    import slc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic blocking,
    input  logic can,
    output logic stall,
    output logic ok,
    output logic carry
);

    slc_cpu_st_t st_d, st_q;
    logic done;

    always_comb begin
        stall = !rst && req && blocking && !can;
        ok    = !rst && req && can;
        done  = !rst && req && !stall;
        st_d  = st_q;
        if (done) begin
            st_d.carry = !can;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign carry = st_q.carry;

endmodule

// File: rtl/strm_link_chan.sv
module strm_link_chan
    import slc_pkg::*;
#(
    parameter slc_dir_e DIR    = DIR_TO_ACC,
    parameter int       DATA_W = 32,
    parameter int       DEPTH  = 4,
    localparam int      WORD_W = DATA_W + 1,
    localparam int      CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_blocking,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wtag,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rtag,
    output logic              cpu_stall,
    output logic              cpu_ok,
    output logic              cpu_carry,
    input  logic              acc_in_valid,
    output logic              acc_in_ready,
    input  logic [DATA_W-1:0] acc_in_data,
    input  logic              acc_in_tag,
    output logic              acc_out_valid,
    input  logic              acc_out_ready,
    output logic [DATA_W-1:0] acc_out_data,
    output logic              acc_out_tag
);

    logic              push, pop, can;
    logic              full, empty;
    logic [WORD_W-1:0] push_word, head;
    logic [CW-1:0]     occ;

    slc_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_word (push_word),
        .pop       (pop),
        .head      (head),
        .occ       (occ),
        .full      (full),
        .empty     (empty)
    );

    slc_cpu_port u_cpu (
        .clk      (clk),
        .rst      (rst),
        .req      (cpu_req),
        .blocking (cpu_blocking),
        .can      (can),
        .stall    (cpu_stall),
        .ok       (cpu_ok),
        .carry    (cpu_carry)
    );

    generate
        if (DIR == DIR_TO_ACC) begin : g_to_acc
            logic unused_in;
            assign unused_in     = ^{acc_in_valid, acc_in_data, acc_in_tag};
            assign acc_out_valid = !empty;
            assign pop           = acc_out_valid && acc_out_ready;
            assign can           = !full || pop;
            assign push          = cpu_ok;
            assign push_word     = {cpu_wtag, cpu_wdata};
            assign acc_out_data  = head[DATA_W-1:0];
            assign acc_out_tag   = head[DATA_W];
            assign cpu_rdata     = '0;
            assign cpu_rtag      = 1'b0;
            assign acc_in_ready  = 1'b0;
        end else begin : g_from_acc
            logic unused_in;
            assign unused_in     = ^{acc_out_ready, cpu_wdata, cpu_wtag};
            assign can           = !empty;
            assign pop           = cpu_ok;
            assign acc_in_ready  = !rst && (!full || pop);
            assign push          = acc_in_valid && acc_in_ready;
            assign push_word     = {acc_in_tag, acc_in_data};
            assign cpu_rdata     = head[DATA_W-1:0];
            assign cpu_rtag      = head[DATA_W];
            assign acc_out_valid = 1'b0;
            assign acc_out_data  = '0;
            assign acc_out_tag   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_blocking,
    input logic              cpu_stall,
    input logic              cpu_ok,
    input logic              cpu_carry,
    input logic              acc_out_valid,
    input logic              acc_out_ready,
    input logic [DATA_W-1:0] acc_out_data,
    input logic              acc_out_tag,
    input logic [CW-1:0]     occ,
    input logic              push,
    input logic              pop
);

    logic rst_seen;

    always_ff @(posedge clk) begin
        if (rst_seen) begin
            a_reset_clears_r11: assert (occ == '0 && !cpu_carry);
        end
        if (rst) begin
            a_reset_no_stall_r11: assert (!cpu_stall && !cpu_ok);
        end
        rst_seen <= rst;
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ <= CW'(DEPTH));

    p_stall_blocking_r4: assert property (@(posedge clk) disable iff (rst)
        cpu_stall |-> (cpu_req && cpu_blocking && !cpu_ok));

    p_nb_fail_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_blocking && !cpu_ok) |=> cpu_carry);

    p_ok_clears_carry_r9: assert property (@(posedge clk) disable iff (rst)
        cpu_ok |=> !cpu_carry);

    p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_out_valid && !acc_out_ready) |=> ($stable(acc_out_data) && $stable(acc_out_tag)));

    p_full_swap_r10: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEPTH) && push && pop) |=> (occ == CW'(DEPTH)));

endmodule

bind strm_link_chan slc_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_slc_chk (
    .clk           (clk),
    .rst           (rst),
    .cpu_req       (cpu_req),
    .cpu_blocking  (cpu_blocking),
    .cpu_stall     (cpu_stall),
    .cpu_ok        (cpu_ok),
    .cpu_carry     (cpu_carry),
    .acc_out_valid (acc_out_valid),
    .acc_out_ready (acc_out_ready),
    .acc_out_data  (acc_out_data),
    .acc_out_tag   (acc_out_tag),
    .occ           (occ),
    .push          (push),
    .pop           (pop)
);

// File: tb/test_strm_link_chan.sv
module test_strm_link_chan;
    import slc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // to-accelerator instance (t_*)
    logic t_req = 0, t_blk = 0, t_wtag = 0, t_ordy = 0;
    logic [DW-1:0] t_wdata = '0;
    logic [DW-1:0] t_rdata, t_odata;
    logic t_rtag, t_stall, t_ok, t_carry, t_irdy, t_ovalid, t_otag;

    // from-accelerator instance (r_*)
    logic r_req = 0, r_blk = 0, r_ival = 0, r_itag = 0;
    logic [DW-1:0] r_idata = '0;
    logic [DW-1:0] r_rdata, r_odata;
    logic r_rtag, r_stall, r_ok, r_carry, r_irdy, r_ovalid, r_otag;

    strm_link_chan #(.DIR(DIR_TO_ACC), .DATA_W(DW), .DEPTH(DEPTH)) i_strm_link_chan (
        .clk(clk), .rst(rst), .cpu_req(t_req), .cpu_blocking(t_blk),
        .cpu_wdata(t_wdata), .cpu_wtag(t_wtag), .cpu_rdata(t_rdata), .cpu_rtag(t_rtag),
        .cpu_stall(t_stall), .cpu_ok(t_ok), .cpu_carry(t_carry),
        .acc_in_valid(1'b0), .acc_in_ready(t_irdy), .acc_in_data('0), .acc_in_tag(1'b0),
        .acc_out_valid(t_ovalid), .acc_out_ready(t_ordy), .acc_out_data(t_odata), .acc_out_tag(t_otag)
    );

    strm_link_chan #(.DIR(DIR_FROM_ACC), .DATA_W(DW), .DEPTH(DEPTH)) i_strm_link_chan_rx (
        .clk(clk), .rst(rst), .cpu_req(r_req), .cpu_blocking(r_blk),
        .cpu_wdata('0), .cpu_wtag(1'b0), .cpu_rdata(r_rdata), .cpu_rtag(r_rtag),
        .cpu_stall(r_stall), .cpu_ok(r_ok), .cpu_carry(r_carry),
        .acc_in_valid(r_ival), .acc_in_ready(r_irdy), .acc_in_data(r_idata), .acc_in_tag(r_itag),
        .acc_out_valid(r_ovalid), .acc_out_ready(1'b0), .acc_out_data(r_odata), .acc_out_tag(r_otag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] wv(input int n, input int i);
        return DW'(32'h1000 * n + i + 32'h55);
    endfunction

    // processor write on the to-accelerator channel, non-blocking unless blk
    task automatic tx_write(input logic blk, input logic [DW-1:0] d, input logic tg, input logic exp_ok);
        @(negedge clk);
        t_req = 1; t_blk = blk; t_wdata = d; t_wtag = tg;
        #1;
        chk("R5 write ok", t_ok, exp_ok);
        chk("R5 write stall", t_stall, blk && !exp_ok);
        @(posedge clk); #1;
        t_req = 0;
        chk("R9 carry after write", t_carry, !exp_ok);
    endtask

    task automatic tx_pop(input logic [DW-1:0] d, input logic tg);
        @(negedge clk); #1;
        chk("R1 out valid", t_ovalid, 1'b1);
        chk("R1 out data", t_odata, d);
        chk("R1 out tag", t_otag, tg);
        t_ordy = 1;
        @(posedge clk); #1;
        t_ordy = 0;
    endtask

    task automatic rx_push(input logic [DW-1:0] d, input logic tg, input logic exp_rdy);
        @(negedge clk);
        r_ival = 1; r_idata = d; r_itag = tg;
        #1;
        chk("R6 in ready", r_irdy, exp_rdy);
        @(posedge clk); #1;
        r_ival = 0;
    endtask

    task automatic rx_read(input logic [DW-1:0] d, input logic tg, input logic exp_ok);
        @(negedge clk);
        r_req = 1; r_blk = 0;
        #1;
        chk("R8 read ok", r_ok, exp_ok);
        chk("R8 read stall", r_stall, 1'b0);
        if (exp_ok) begin
            chk("R6 read data", r_rdata, d);
            chk("R6 read tag", r_rtag, tg);
        end
        @(posedge clk); #1;
        r_req = 0;
        chk("R9 carry after read", r_carry, !exp_ok);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk); #1;
        chk("R11 tx valid after reset", t_ovalid, 1'b0);
        chk("R11 tx carry after reset", t_carry, 1'b0);
        chk("R11 rx ready after reset", r_irdy, 1'b1);
        chk("R11 rx carry after reset", r_carry, 1'b0);

        // R1 R3 R5: sweep fill levels to-accelerator
        for (int n = 0; n <= DEPTH + 2; n++) begin
            for (int i = 0; i < n; i++) tx_write(1'b0, wv(n, i), i[0], i < DEPTH);
            for (int i = 0; i < n && i < DEPTH; i++) tx_pop(wv(n, i), i[0]);
            @(negedge clk); #1;
            chk("R3 drained empty", t_ovalid, 1'b0);
        end

        // R2: word held while ready low
        tx_write(1'b0, 32'hCAFE0001, 1'b1, 1'b1);
        tx_write(1'b0, 32'hCAFE0002, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk("R2 hold data", t_odata, 32'hCAFE0001);
            chk("R2 hold tag", t_otag, 1'b1);
        end
        tx_pop(32'hCAFE0001, 1'b1);
        tx_pop(32'hCAFE0002, 1'b0);

        // R4 R10: blocking write against full, released by a pop
        for (int i = 0; i < DEPTH; i++) tx_write(1'b0, 32'hA0 + i, 1'b0, 1'b1);
        @(negedge clk);
        t_req = 1; t_blk = 1; t_wdata = 32'hBEEF; t_wtag = 1;
        #1;
        chk("R4 stall when full", t_stall, 1'b1);
        chk("R4 no ok when full", t_ok, 1'b0);
        @(negedge clk); #1;
        chk("R4 still stalled", t_stall, 1'b1);
        t_ordy = 1;
        #1;
        chk("R4 released by pop", t_stall, 1'b0);
        chk("R4 completes with pop", t_ok, 1'b1);
        @(posedge clk); #1;
        t_req = 0; t_ordy = 0; t_blk = 0;
        tx_write(1'b0, 32'hDEAD, 1'b0, 1'b0); // R10: still full
        for (int i = 1; i < DEPTH; i++) tx_pop(32'hA0 + i, 1'b0);
        tx_pop(32'hBEEF, 1'b1);

        // R11: reset while full with a pending blocking write and carry set
        for (int i = 0; i < DEPTH; i++) tx_write(1'b0, 32'h77 + i, 1'b0, 1'b1);
        tx_write(1'b0, 32'h99, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1; t_req = 1; t_blk = 1;
        #1;
        chk("R11 no stall in reset", t_stall, 1'b0);
        @(posedge clk); #1;
        rst = 0; t_req = 0; t_blk = 0;
        chk("R11 emptied", t_ovalid, 1'b0);
        chk("R11 carry cleared", t_carry, 1'b0);

        // R6 R8: sweep fill levels from-accelerator
        for (int n = 0; n <= DEPTH + 2; n++) begin
            for (int i = 0; i < n; i++) rx_push(wv(n, i) ^ 32'hFF00, i[0], i < DEPTH);
            for (int i = 0; i <= n && i <= DEPTH; i++)
                rx_read(wv(n, i) ^ 32'hFF00, i[0], i < n && i < DEPTH);
        end

        // R7: blocking read on empty, no same-cycle bypass
        @(negedge clk);
        r_req = 1; r_blk = 1;
        #1;
        chk("R7 stall when empty", r_stall, 1'b1);
        r_ival = 1; r_idata = 32'h5151; r_itag = 1;
        #1;
        chk("R7 no bypass", r_stall, 1'b1);
        @(posedge clk); #1;
        r_ival = 0;
        chk("R7 completes next cycle", r_ok, 1'b1);
        chk("R7 data", r_rdata, 32'h5151);
        @(posedge clk); #1;
        r_req = 0; r_blk = 0;
        chk("R9 carry after blocking read", r_carry, 1'b0);

        // R10: push and pop together at full
        for (int i = 0; i < DEPTH; i++) rx_push(32'hC0 + i, i[0], 1'b1);
        @(negedge clk);
        r_ival = 1; r_idata = 32'hEE; r_itag = 1; r_req = 1; r_blk = 0;
        #1;
        chk("R10 ready at full with pop", r_irdy, 1'b1);
        chk("R10 read ok at full", r_ok, 1'b1);
        chk("R10 read head", r_rdata, 32'hC0);
        @(posedge clk); #1;
        r_ival = 0; r_req = 0;
        #1;
        chk("R10 still full", r_irdy, 1'b0);
        for (int i = 1; i < DEPTH; i++) rx_read(32'hC0 + i, i[0], 1'b1);
        rx_read(32'hEE, 1'b1, 1'b1);
        rx_read(32'h0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule